// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a memory-mapped SPI master with a 32-bit register file. Software programs a mode word (clock phase, idle polarity, bit order, loopback, word length, prescaler, enable), writes a transmit word, and the engine shifts exactly one word per write. A receive-not-empty event is raised once the word has been captured. A transmit-not-full status reports whether the one-word holding buffer can take another write. An interrupt output combines the events with a per-event mask. Native slave-select lines are driven straight from a bit-per-select register.

Data is justified inside the 32-bit transmit and receive registers, and where it sits depends on word length and bit order. Mode changes follow a two-step sequence: the new value is first written with enable low, then written again with enable high. While enable is low the engine accepts nothing and stops at once.

Top module: `spim_top`

## Requirements
- R1: After reset: mode (offset 0) reads 0, event (offset 1) reads 2 (bit 0 NE = 0, bit 1 NF = 1), select (offset 6) reads all ones, `irq_o` = 0 and `sclk_o` = 0. The other offsets are mask 2, command 3 (reads 0), transmit 4 and receive 5.
- R2: Mode bits [11:8] hold word length minus one. Field value 0 selects 32-bit words. Lengths 4 to 16 and 32 each shift exactly that many bits.
- R3: With mode bit 3 set (MSB first) and length n ≤ 16, the transmit data is taken from bits [31:32-n] and sent MSB first. The received word reads back shifted left by 16.
- R4: With mode bit 3 clear (LSB first) and n ≤ 16, the transmit data is taken from bits [n-1:0] and sent LSB first. The received word reads back shifted left by 16-n.
- R5: For 32-bit words, neither transmit nor receive data is shifted. The bit order still follows mode bit 3.
- R6: `sclk_o` idles at mode bit 2 (polarity). Each half period lasts (pm+1) clocks, times 16 when bit 20 is set, where pm is bits [19:16]. With bit 1 (phase) clear, MOSI is valid before the first edge and sampled on leading edges. With bit 1 set, MOSI changes on leading edges and is sampled on trailing edges.
- R7: NE (event bit 0) becomes visible 2·n·L+2 clocks after the clock edge that accepts a transmit write, where L is the half period. Writing 1 to bit 0 clears NE. NF (bit 1) is live: it is 0 while a word waits in the buffer.
- R8: Only one word can wait while the engine is busy. That word starts as soon as the current word ends. A transmit write while the buffer is full is dropped.
- R9: With enable (mode bit 0) clear, transmit writes are ignored. Clearing enable aborts a running word without raising NE, empties the buffer and returns `sclk_o` to idle.
- R10: With mode bit 4 set (loopback), the serial output is fed back as the serial input and `miso_i` has no effect. With bit 4 clear, data is captured from `miso_i`.
- R11: `irq_o` is the OR of event bits ANDed with mask bits at the same positions.
- R12: Select register bit k drives `ss_no[k]` directly, so writing 0 asserts that select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NSEL | Active-low native selects |
| irq_o | output | 1 | Interrupt request |

## Verification
The engine takes a word from the buffer one clock after the write edge. SPI clock edges then come every L clocks. The completion flag is registered at the last trailing edge, and NE and the receive register update one clock after that. So the bench counts exactly 2·n·L+1 edges after the write and checks that NE is still low, then checks one edge later that it is high. NF is checked on the clock after the write and again one clock after the word is taken. All outputs are sampled between edges. MOSI is captured on the sampling edge of `sclk_o` that the selected phase and polarity define.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_EVT  = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd3;
  localparam logic [2:0] A_TX   = 3'd4;
  localparam logic [2:0] A_RX   = 3'd5;
  localparam logic [2:0] A_SEL  = 3'd6;

  typedef struct packed {
    logic [10:0] rsv_hi;
    logic        div16;
    logic [3:0]  pm;
    logic [3:0]  rsv_mid;
    logic [3:0]  len;
    logic [2:0]  rsv_lo;
    logic        loop;
    logic        msbf;
    logic        cpol;
    logic        cpha;
    logic        en;
  } mode_t;

  function automatic logic [5:0] word_len(input logic [3:0] f);
    return (f == 4'd0) ? 6'd32 : ({2'b00, f} + 6'd1);
  endfunction

  function automatic logic [31:0] len_mask(input logic [5:0] n);
    return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // register word -> right-justified data
  function automatic logic [31:0] tx_unpack(input logic [31:0] w, input logic [5:0] n,
                                            input logic msbf);
    if (n <= 6'd16 && msbf) return w >> (6'd32 - n);
    return w & len_mask(n);
  endfunction

  // right-justified data -> register word
  function automatic logic [31:0] rx_pack(input logic [31:0] d, input logic [5:0] n,
                                          input logic msbf);
    if (n <= 6'd16) return msbf ? (d << 16) : (d << (6'd16 - n));
    return d;
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PMW = 4,
  parameter int CW  = PMW + 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [PMW-1:0] pm_i,
  input  logic           div16_i,
  output logic           tick_o
);
  logic [CW-1:0] cnt_q, limit;

  always_comb begin
    limit = {{(CW-PMW){1'b0}}, pm_i} + {{(CW-1){1'b0}}, 1'b1};
    if (div16_i) limit = limit << 4;
  end

  assign tick_o = run_i && (cnt_q >= limit - {{(CW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  p_cnt_lim_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] len_i,
  input  logic          msbf_i,
  input  logic          cpha_i,
  input  logic          cpol_i,
  input  logic          loop_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sclk_o,
  output logic          mosi_o
);
  logic          busy_q, ph_q, done_q, mosi_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] sr_q, rx_q, sr_ld, sr_nx, mask;
  logic          din, lead, samp;

  assign din   = loop_i ? mosi_q : miso_i;
  assign lead  = ~ph_q;
  assign samp  = lead ^ cpha_i;
  assign sr_ld = msbf_i ? (data_i << (LW'(DW) - len_i)) : data_i;
  assign sr_nx = msbf_i ? {sr_q[DW-2:0], 1'b0} : {1'b0, sr_q[DW-1:1]};
  assign mask  = (len_i >= LW'(DW)) ? '1 : ((DW'(1) << len_i) - DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; ph_q <= 1'b0; done_q <= 1'b0; mosi_q <= 1'b0;
      cnt_q <= '0; sr_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
        sr_q   <= sr_ld;
        mosi_q <= msbf_i ? sr_ld[DW-1] : sr_ld[0];
        rx_q   <= '0;
      end else if (busy_q && tick_i) begin
        ph_q <= ~ph_q;
        if (samp) begin
          rx_q <= msbf_i ? {rx_q[DW-2:0], din} : {din, rx_q[DW-1:1]};
        end else if (!cpha_i) begin
          sr_q   <= sr_nx;
          mosi_q <= msbf_i ? sr_nx[DW-1] : sr_nx[0];
        end else begin
          mosi_q <= msbf_i ? sr_q[DW-1] : sr_q[0];
          sr_q   <= sr_nx;
        end
        if (!lead) begin
          cnt_q <= cnt_q + LW'(1);
          if (cnt_q == len_i - LW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sclk_o = cpol_i ^ ph_q;
  assign mosi_o = mosi_q;
  assign rx_o   = msbf_i ? (rx_q & mask) : (rx_q >> (LW'(DW) - len_i));

  p_sclk_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (sclk_o == cpol_i));
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_cnt_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < len_i));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic [NSEL-1:0] ss_no,
  output logic            irq_o
);
  localparam int DW = 32;
  localparam int LW = $clog2(DW) + 1;

  mode_t           mode_q;
  logic            ne_q, pend_v_q, nf;
  logic [1:0]      mask_q;
  logic [DW-1:0]   pend_q, rx_q, sh_rx;
  logic [NSEL-1:0] sel_q;
  logic [LW-1:0]   n;
  logic            start, wr_tx, busy, done, tick;

  assign n     = word_len(mode_q.len);
  assign nf    = ~pend_v_q;
  assign start = pend_v_q && !busy && mode_q.en;
  assign wr_tx = we_i && (addr_i == A_TX) && mode_q.en && !pend_v_q;

  spim_clkdiv #(.PMW(4)) u_div (
    .clk_i, .rst_ni,
    .run_i  (busy && mode_q.en),
    .pm_i   (mode_q.pm),
    .div16_i(mode_q.div16),
    .tick_o (tick)
  );

  spim_shift #(.DW(DW)) u_sh (
    .clk_i, .rst_ni,
    .start_i(start),
    .abort_i(!mode_q.en),
    .data_i (pend_q),
    .len_i  (n),
    .msbf_i (mode_q.msbf),
    .cpha_i (mode_q.cpha),
    .cpol_i (mode_q.cpol),
    .loop_i (mode_q.loop),
    .tick_i (tick),
    .miso_i (miso_i),
    .busy_o (busy),
    .done_o (done),
    .rx_o   (sh_rx),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; mask_q <= '0; sel_q <= '1;
    end else if (we_i) begin
      if (addr_i == A_MODE) mode_q <= mode_t'(wdata_i);
      if (addr_i == A_MASK) mask_q <= wdata_i[1:0];
      if (addr_i == A_SEL)  sel_q  <= wdata_i[NSEL-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0; pend_q <= '0;
    end else if (!mode_q.en || start) begin
      pend_v_q <= 1'b0;
    end else if (wr_tx) begin
      pend_v_q <= 1'b1;
      pend_q   <= tx_unpack(wdata_i, n, mode_q.msbf);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ne_q <= 1'b0; rx_q <= '0;
    end else begin
      if (done) begin
        ne_q <= 1'b1;
        rx_q <= rx_pack(sh_rx, n, mode_q.msbf);
      end else if (we_i && addr_i == A_EVT && wdata_i[0]) begin
        ne_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_EVT:   rdata_o = {30'd0, nf, ne_q};
      A_MASK:  rdata_o = {30'd0, mask_q};
      A_RX:    rdata_o = rx_q;
      A_SEL:   rdata_o = {{(32-NSEL){1'b0}}, sel_q};
      default: rdata_o = '0;
    endcase
  end

  assign ss_no = sel_q;
  assign irq_o = |({nf, ne_q} & mask_q);

  p_ne_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ne_q);
  p_off_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.en |=> !busy);
  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v_q && !start && mode_q.en && we_i && addr_i == A_TX) |=> $stable(pend_q));
  p_irq_ne_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ne_q && mask_q[0]) |-> irq_o);
endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  ss_n;
  logic        irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign miso = ~mosi;

  spim_top #(.NSEL(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .ss_no(ss_n), .irq_o(irq)
  );

  // MOSI monitor on the sampling edge
  logic        cur_cpha = 1'b0, cur_cpol = 1'b0;
  logic [31:0] mon_bits = '0;
  int          mon_cnt = 0;
  always @(posedge sclk) if (!(cur_cpol ^ cur_cpha)) begin
    if (mon_cnt < 32) mon_bits[mon_cnt] = mosi;
    mon_cnt++;
  end
  always @(negedge sclk) if (cur_cpol ^ cur_cpha) begin
    if (mon_cnt < 32) mon_bits[mon_cnt] = mosi;
    mon_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  function automatic logic [31:0] mode_w(input int n, input bit en, input bit cpha,
      input bit cpol, input bit msb, input bit loop, input int pm, input bit d16);
    logic [3:0] f = (n == 32) ? 4'd0 : 4'(n - 1);
    return {11'd0, d16, 4'(pm), 4'd0, f, 3'd0, loop, msb, cpol, cpha, en};
  endfunction

  task automatic set_mode(input int n, input bit cpha, input bit cpol, input bit msb,
                          input bit loop, input int pm, input bit d16);
    wr(3'd0, mode_w(n, 1'b0, cpha, cpol, msb, loop, pm, d16));
    wr(3'd0, mode_w(n, 1'b1, cpha, cpol, msb, loop, pm, d16));
    cur_cpha = cpha; cur_cpol = cpol;
  endtask

  task automatic xfer(input int n, input bit cpha, input bit cpol, input bit msb,
                      input bit loop, input int pm, input bit d16, input logic [31:0] d);
    logic [31:0] v, txw, dr, ex, eb;
    int L;
    L = (pm + 1) * (d16 ? 16 : 1);
    set_mode(n, cpha, cpol, msb, loop, pm, d16);
    wr(3'd1, 32'h1);
    mon_cnt = 0;
    d = d & msk(n);
    txw = (n <= 16 && msb) ? (d << (32 - n)) : d;   // R3 R4 R5
    wr(3'd4, txw);
    repeat (2 * n * L + 1) @(posedge clk);
    #2 rd(3'd1, v);
    chk("R7 NE not early", {31'd0, v[0]}, 32'd0);
    @(posedge clk);
    #2 rd(3'd1, v);
    chk("R7 NE on time", {31'd0, v[0]}, 32'd1);
    dr = loop ? d : (~d & msk(n));                   // R10
    ex = (n <= 16) ? (msb ? (dr << 16) : (dr << (16 - n))) : dr;
    rd(3'd5, v);
    chk(n == 32 ? "R5 rx" : (msb ? "R3 rx" : "R4 rx"), v, ex);
    chk("R2 bit count", mon_cnt, n);
    eb = '0;
    for (int k = 0; k < n; k++) eb[k] = msb ? d[n - 1 - k] : d[k];
    chk("R6 mosi order/phase", mon_bits & msk(n), eb);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 32'd0);
    rd(3'd1, v); chk("R1 event", v, 32'd2);
    rd(3'd6, v); chk("R1 sel", v, 32'hF);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R12 ss reset", {28'd0, ss_n}, 32'hF);
    // R12
    wr(3'd6, 32'h5);
    #2 chk("R12 ss drive", {28'd0, ss_n}, 32'h5);
    // R11 with live NF
    wr(3'd2, 32'h2);
    #2 chk("R11 irq NF", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h0);
    #2 chk("R11 irq masked", {31'd0, irq}, 32'd0);

    // sweep lengths, orders, modes; loopback and external
    for (int lp = 1; lp >= 0; lp--)
      for (int n = 4; n <= 32; n++) begin
        if (n > 16 && n < 32) continue;
        for (int m = 0; m < 2; m++)
          xfer(n, 1'((n + m) & 1), 1'(((n + m) >> 1) & 1), 1'(m), 1'(lp), 0, 1'b0,
               32'hA5C3_96E1 ^ (32'h0101_0101 * n) ^ (32'h3C << m));
      end
    // divider settings
    xfer(8, 1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b0, 32'h96);
    xfer(4, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b1, 32'h9);
    xfer(32, 1'b1, 1'b1, 1'b1, 1'b1, 15, 1'b0, 32'hDEAD_BEEF);

    // R11 / R7 W1C
    wr(3'd2, 32'h1);
    #2 chk("R11 irq NE", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h1);
    #2 rd(3'd1, v); chk("R7 W1C", {31'd0, v[0]}, 32'd0);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h0);

    // R8 one-word buffer
    set_mode(8, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    mon_cnt = 0;
    wr(3'd4, 32'h1100_0000);
    #2 rd(3'd1, v); chk("R7 NF low after write", {31'd0, v[1]}, 32'd0);
    @(posedge clk);
    #2 rd(3'd1, v); chk("R7 NF high after start", {31'd0, v[1]}, 32'd1);
    wr(3'd4, 32'h2200_0000);
    #2 rd(3'd1, v); chk("R8 NF buffered", {31'd0, v[1]}, 32'd0);
    wr(3'd4, 32'h3300_0000);
    repeat (16) @(posedge clk);
    #2 rd(3'd5, v); chk("R8 first word", v, 32'h0011_0000);
    wr(3'd1, 32'h1);
    repeat (20) @(posedge clk);
    #2 rd(3'd5, v); chk("R8 second word", v, 32'h0022_0000);
    rd(3'd1, v); chk("R8 NE and NF", v, 32'd3);
    chk("R8 bits sent", mon_cnt, 16);
    wr(3'd1, 32'h1);
    repeat (40) @(posedge clk);
    #2 rd(3'd1, v); chk("R8 third dropped", {31'd0, v[0]}, 32'd0);

    // R9 abort and disabled writes
    set_mode(32, 1'b0, 1'b1, 1'b1, 1'b1, 3, 1'b0);
    wr(3'd4, 32'h1234_5678);
    @(posedge clk);
    wr(3'd4, 32'h8765_4321);
    repeat (20) @(posedge clk);
    wr(3'd0, mode_w(32, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3, 1'b0));
    @(posedge clk);
    #2 chk("R9 sclk idle", {31'd0, sclk}, 32'd1);
    rd(3'd1, v); chk("R9 buffer emptied", {31'd0, v[1]}, 32'd1);
    repeat (300) @(posedge clk);
    #2 rd(3'd1, v); chk("R9 no NE after abort", {31'd0, v[0]}, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    #2 rd(3'd1, v); chk("R9 write ignored", {31'd0, v[1]}, 32'd1);
    repeat (50) @(posedge clk);
    #2 rd(3'd1, v); chk("R9 still no NE", {31'd0, v[0]}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule